// File: doc/BRIEF.md
# Sticky Flash Security Lock Gate

This block sits between the flash access paths and the flash array and applies a one-bit security lock. Reads arrive from an instruction-fetch port and a data port. Program requests arrive from a peripheral bus. Page-erase and mass-erase requests arrive as well. For every request the block decides in the same cycle whether it reaches the array. Reads come back with a grant, a fault flag and data. Write-type requests become a command strobe toward the array, or else an error pulse on the following cycle.

The lock is write-one-to-set and needs a valid key. Software first loads a 32-bit key register with the expected constant and then writes a one to the lock. A successful set uses up the key. Once the lock is set, no write can clear it, and neither can the soft system reset: only the power-on/external reset does.

While the lock is set, reads fault with zeroed data and program requests are refused. Erases stay possible, but only where the per-page write-protect vector permits them. While the lock is clear, reads and program requests pass straight through.

Top module: `flash_lock_gate`

## Requirements
- R1: Writing the lock with lockWrBit=1 while the key is valid sets lockState on the next cycle. Writing lockWrBit=0 has no effect, and no lock write ever clears lockState.
- R2: Only porRstN low clears lockState. sysRstN low clears the key register and errPulse but leaves lockState as it was. Lock writes are ignored while either reset is low.
- R3: The key is valid only when the key register equals KEY_VALUE, which keyArmed reports. A lock write with an invalid key leaves lockState clear and leaves the key register unchanged.
- R4: A successful lock set clears the key register on the same edge, and this wins over a key write in that cycle.
- R5: While locked, a valid read on either port gives fault=1, grant=0 and read data 0 in the same cycle.
- R6: While unlocked, a valid read on either port gives grant=1, fault=0, and the flash data passed through. With no valid read, grant and fault are 0 and the data is 0.
- R7: A program request drives pgmCmdValid in the same cycle, with its address and data passed through, only when unlocked. While locked the command is suppressed.
- R8: A page-erase request drives pageCmdValid only when wrProt[pageIdx] is 0, whether locked or not.
- R9: A mass-erase request drives massCmdValid only when every bit of wrProt is 0, whether locked or not.
- R10: errPulse is 1 in the cycle after any cycle that has a refused program, page-erase or mass-erase request, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on/external reset, active low, synchronous |
| sysRstN | input | 1 | Soft system reset, active low, synchronous |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrData | input | KEY_W | Key value to store |
| lockWrEn | input | 1 | Lock register write strobe |
| lockWrBit | input | 1 | Lock write data; 1 requests set |
| lockState | output | 1 | Current lock value |
| keyArmed | output | 1 | Key register holds the valid key |
| wrProt | input | NUM_PAGES | Per-page write protect, 1 = protected |
| iReqValid | input | 1 | Instruction-port read request |
| iFlashData | input | DATA_W | Array data for the instruction port |
| iGrant | output | 1 | Instruction read granted |
| iFault | output | 1 | Instruction read faulted |
| iRdData | output | DATA_W | Gated instruction read data |
| dReqValid | input | 1 | Data-port read request |
| dFlashData | input | DATA_W | Array data for the data port |
| dGrant | output | 1 | Data read granted |
| dFault | output | 1 | Data read faulted |
| dRdData | output | DATA_W | Gated data read data |
| pgmValid | input | 1 | Program request |
| pgmAddr | input | ADDR_W | Program address |
| pgmData | input | DATA_W | Program data |
| pgmCmdValid | output | 1 | Program command to array |
| pgmCmdAddr | output | ADDR_W | Program command address |
| pgmCmdData | output | DATA_W | Program command data |
| pageValid | input | 1 | Page-erase request |
| pageIdx | input | PAGE_W | Page to erase |
| pageCmdValid | output | 1 | Page-erase command to array |
| pageCmdIdx | output | PAGE_W | Page-erase command page |
| massValid | input | 1 | Mass-erase request |
| massCmdValid | output | 1 | Mass-erase command to array |
| errPulse | output | 1 | Refused write or erase, one cycle later |

## Verification
The bench builds the block with NUM_PAGES=8, ADDR_W=12 and a non-default KEY_VALUE. The small page count lets the bench exercise single protected pages, an all-clear vector and a fully protected vector directly. The changed key shows that the comparison follows the parameter rather than a hard-wired constant. These values bring into reach the interplay of the two resets with the sticky lock, key use-up against a simultaneous key write, and erases that are refused or allowed on either side of the lock.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef struct packed {
    logic rdAllow;
    logic pgmAllow;
    logic pageAllow;
    logic massAllow;
    logic deny;
  } gateStrobes_t;
endpackage

// File: rtl/flg_ctrl.sv
module flg_ctrl
  import flg_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = 32'h5EC0_1234,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 sysRstN,
  input  logic                 keyWrEn,
  input  logic [KEY_W-1:0]     keyWrData,
  input  logic                 lockWrEn,
  input  logic                 lockWrBit,
  input  logic [NUM_PAGES-1:0] wrProt,
  input  logic                 pgmValid,
  input  logic                 pageValid,
  input  logic [PAGE_W-1:0]    pageIdx,
  input  logic                 massValid,
  output gateStrobes_t         strobes,
  output logic                 lockState,
  output logic                 keyArmed
);
  logic [KEY_W-1:0] keyReg;
  logic lockReg;
  logic keyOk;
  logic setAccept;
  logic pageProt;
  logic anyProt;

  assign keyOk     = (keyReg == KEY_VALUE);
  assign setAccept = lockWrEn && lockWrBit && keyOk;
  assign pageProt  = (int'(pageIdx) < NUM_PAGES) ? wrProt[pageIdx] : 1'b1;
  assign anyProt   = |wrProt;

  // Sticky lock: cleared only by the power-on/external reset
  always_ff @(posedge clk) begin
    if (!porRstN) lockReg <= 1'b0;
    else if (sysRstN && setAccept) lockReg <= 1'b1;
  end

  // Key register: cleared by either reset, used up by a successful set
  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) keyReg <= '0;
    else if (setAccept) keyReg <= '0;
    else if (keyWrEn) keyReg <= keyWrData;
  end

  always_comb begin
    strobes.rdAllow   = !lockReg;
    strobes.pgmAllow  = pgmValid && !lockReg;
    strobes.pageAllow = pageValid && !pageProt;
    strobes.massAllow = massValid && !anyProt;
    strobes.deny      = (pgmValid && lockReg) || (pageValid && pageProt)
                      || (massValid && anyProt);
  end

  assign lockState = lockReg;
  assign keyArmed  = keyOk;
endmodule

// File: rtl/flg_datapath.sv
module flg_datapath
  import flg_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int RD_PORTS = 2
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  gateStrobes_t       strobes,
  input  logic               iReqValid,
  input  logic [DATA_W-1:0]  iFlashData,
  input  logic               dReqValid,
  input  logic [DATA_W-1:0]  dFlashData,
  input  logic [ADDR_W-1:0]  pgmAddr,
  input  logic [DATA_W-1:0]  pgmData,
  input  logic [PAGE_W-1:0]  pageIdx,
  output logic               iGrant,
  output logic               iFault,
  output logic [DATA_W-1:0]  iRdData,
  output logic               dGrant,
  output logic               dFault,
  output logic [DATA_W-1:0]  dRdData,
  output logic               pgmCmdValid,
  output logic [ADDR_W-1:0]  pgmCmdAddr,
  output logic [DATA_W-1:0]  pgmCmdData,
  output logic               pageCmdValid,
  output logic [PAGE_W-1:0]  pageCmdIdx,
  output logic               massCmdValid,
  output logic               errPulse
);
  logic [RD_PORTS-1:0]             rdValid;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdIn;
  logic [RD_PORTS-1:0]             rdGrant;
  logic [RD_PORTS-1:0]             rdFault;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdOut;
  logic errReg;

  assign rdValid = {dReqValid, iReqValid};
  assign rdIn    = {dFlashData, iFlashData};

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdPort
    assign rdGrant[p] = rdValid[p] && strobes.rdAllow;
    assign rdFault[p] = rdValid[p] && !strobes.rdAllow;
    assign rdOut[p]   = rdGrant[p] ? rdIn[p] : '0;
  end

  assign iGrant  = rdGrant[0];
  assign iFault  = rdFault[0];
  assign iRdData = rdOut[0];
  assign dGrant  = rdGrant[1];
  assign dFault  = rdFault[1];
  assign dRdData = rdOut[1];

  assign pgmCmdValid  = strobes.pgmAllow;
  assign pgmCmdAddr   = pgmAddr;
  assign pgmCmdData   = pgmData;
  assign pageCmdValid = strobes.pageAllow;
  assign pageCmdIdx   = pageIdx;
  assign massCmdValid = strobes.massAllow;

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) errReg <= 1'b0;
    else errReg <= strobes.deny;
  end
  assign errPulse = errReg;
endmodule

// File: rtl/flash_lock_gate.sv
module flash_lock_gate
  import flg_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = 32'h5EC0_1234,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 sysRstN,
  input  logic                 keyWrEn,
  input  logic [KEY_W-1:0]     keyWrData,
  input  logic                 lockWrEn,
  input  logic                 lockWrBit,
  output logic                 lockState,
  output logic                 keyArmed,
  input  logic [NUM_PAGES-1:0] wrProt,
  input  logic                 iReqValid,
  input  logic [DATA_W-1:0]    iFlashData,
  output logic                 iGrant,
  output logic                 iFault,
  output logic [DATA_W-1:0]    iRdData,
  input  logic                 dReqValid,
  input  logic [DATA_W-1:0]    dFlashData,
  output logic                 dGrant,
  output logic                 dFault,
  output logic [DATA_W-1:0]    dRdData,
  input  logic                 pgmValid,
  input  logic [ADDR_W-1:0]    pgmAddr,
  input  logic [DATA_W-1:0]    pgmData,
  output logic                 pgmCmdValid,
  output logic [ADDR_W-1:0]    pgmCmdAddr,
  output logic [DATA_W-1:0]    pgmCmdData,
  input  logic                 pageValid,
  input  logic [PAGE_W-1:0]    pageIdx,
  output logic                 pageCmdValid,
  output logic [PAGE_W-1:0]    pageCmdIdx,
  input  logic                 massValid,
  output logic                 massCmdValid,
  output logic                 errPulse
);
  gateStrobes_t strobes;

  flg_ctrl #(
    .NUM_PAGES(NUM_PAGES), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)
  ) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .lockWrEn(lockWrEn), .lockWrBit(lockWrBit),
    .wrProt(wrProt), .pgmValid(pgmValid), .pageValid(pageValid),
    .pageIdx(pageIdx), .massValid(massValid),
    .strobes(strobes), .lockState(lockState), .keyArmed(keyArmed)
  );

  flg_datapath #(
    .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .strobes(strobes),
    .iReqValid(iReqValid), .iFlashData(iFlashData),
    .dReqValid(dReqValid), .dFlashData(dFlashData),
    .pgmAddr(pgmAddr), .pgmData(pgmData), .pageIdx(pageIdx),
    .iGrant(iGrant), .iFault(iFault), .iRdData(iRdData),
    .dGrant(dGrant), .dFault(dFault), .dRdData(dRdData),
    .pgmCmdValid(pgmCmdValid), .pgmCmdAddr(pgmCmdAddr), .pgmCmdData(pgmCmdData),
    .pageCmdValid(pageCmdValid), .pageCmdIdx(pageCmdIdx),
    .massCmdValid(massCmdValid), .errPulse(errPulse)
  );
endmodule

// File: rtl/flg_checker.sv
module flg_checker #(
  parameter int NUM_PAGES = 64,
  parameter int DATA_W = 32,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input logic                 clk,
  input logic                 porRstN,
  input logic                 sysRstN,
  input logic                 lockState,
  input logic                 lockWrEn,
  input logic                 keyArmed,
  input logic [NUM_PAGES-1:0] wrProt,
  input logic                 iReqValid,
  input logic                 iGrant,
  input logic                 iFault,
  input logic [DATA_W-1:0]    iRdData,
  input logic                 dReqValid,
  input logic                 dGrant,
  input logic                 dFault,
  input logic [DATA_W-1:0]    dRdData,
  input logic                 pgmValid,
  input logic                 pgmCmdValid,
  input logic                 pageCmdValid,
  input logic [PAGE_W-1:0]    pageIdx,
  input logic                 massCmdValid,
  input logic                 errPulse
);
  p_lock_sticky_r1: assert property (@(posedge clk) disable iff (!porRstN)
    lockState |=> lockState);

  p_lock_needs_write_r1: assert property (@(posedge clk) disable iff (!porRstN)
    !lockState |=> (!lockState || $past(lockWrEn)));

  p_key_used_r4: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    $rose(lockState) |-> !keyArmed);

  p_i_locked_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (lockState && iReqValid) |-> (iFault && !iGrant && iRdData == '0));

  p_d_locked_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (lockState && dReqValid) |-> (dFault && !dGrant && dRdData == '0));

  p_pgm_blocked_r7: assert property (@(posedge clk) disable iff (!porRstN)
    lockState |-> !pgmCmdValid);

  p_page_prot_r8: assert property (@(posedge clk) disable iff (!porRstN)
    pageCmdValid |-> !wrProt[pageIdx]);

  p_mass_prot_r9: assert property (@(posedge clk) disable iff (!porRstN)
    massCmdValid |-> (wrProt == '0));

  p_pgm_err_r10: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (pgmValid && !pgmCmdValid) |=> errPulse);
endmodule

bind flash_lock_gate flg_checker #(.NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .lockState(lockState),
  .lockWrEn(lockWrEn), .keyArmed(keyArmed), .wrProt(wrProt),
  .iReqValid(iReqValid), .iGrant(iGrant), .iFault(iFault), .iRdData(iRdData),
  .dReqValid(dReqValid), .dGrant(dGrant), .dFault(dFault), .dRdData(dRdData),
  .pgmValid(pgmValid), .pgmCmdValid(pgmCmdValid), .pageCmdValid(pageCmdValid),
  .pageIdx(pageIdx), .massCmdValid(massCmdValid), .errPulse(errPulse)
);

// File: tb/flash_lock_gate_bench.sv
`timescale 1ns/1ps
module flash_lock_gate_bench;
  localparam int NP = 8;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int KW = 32;
  localparam logic [KW-1:0] KEY = 32'hC0DE_5AFE;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic porRstN, sysRstN, keyWrEn, lockWrEn, lockWrBit;
  logic [KW-1:0] keyWrData;
  logic lockState, keyArmed;
  logic [NP-1:0] wrProt;
  logic iReqValid, dReqValid, iGrant, iFault, dGrant, dFault;
  logic [DW-1:0] iFlashData, dFlashData, iRdData, dRdData;
  logic pgmValid, pgmCmdValid;
  logic [AW-1:0] pgmAddr, pgmCmdAddr;
  logic [DW-1:0] pgmData, pgmCmdData;
  logic pageValid, pageCmdValid, massValid, massCmdValid, errPulse;
  logic [PW-1:0] pageIdx, pageCmdIdx;

  flash_lock_gate #(.NUM_PAGES(NP), .ADDR_W(AW), .DATA_W(DW), .KEY_W(KW), .KEY_VALUE(KEY))
  u_flash_lock_gate (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // Behavioural reference state
  bit mLock = 0;
  longint mKey = 0;
  bit mErr = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Compare outputs for the current inputs, then advance the model across one edge
  task automatic step();
    bit prot, anyProt, deny, setOk;
    #2;
    prot = wrProt[pageIdx];
    anyProt = (wrProt != 0);
    chk("R1/R2 lockState", lockState, mLock);
    chk("R3 keyArmed", keyArmed, mKey == longint'(KEY));
    chk("R5/R6 iGrant", iGrant, iReqValid && !mLock);
    chk("R5/R6 iFault", iFault, iReqValid && mLock);
    chk("R5/R6 iRdData", iRdData, (iReqValid && !mLock) ? iFlashData : 0);
    chk("R5/R6 dGrant", dGrant, dReqValid && !mLock);
    chk("R5/R6 dFault", dFault, dReqValid && mLock);
    chk("R5/R6 dRdData", dRdData, (dReqValid && !mLock) ? dFlashData : 0);
    chk("R7 pgmCmdValid", pgmCmdValid, pgmValid && !mLock);
    chk("R7 pgmCmdAddr", pgmCmdAddr, pgmAddr);
    chk("R7 pgmCmdData", pgmCmdData, pgmData);
    chk("R8 pageCmdValid", pageCmdValid, pageValid && !prot);
    chk("R8 pageCmdIdx", pageCmdIdx, pageIdx);
    chk("R9 massCmdValid", massCmdValid, massValid && !anyProt);
    chk("R10 errPulse", errPulse, mErr);
    deny = (pgmValid && mLock) || (pageValid && prot) || (massValid && anyProt);
    setOk = lockWrEn && lockWrBit && (mKey == longint'(KEY));
    if (!porRstN) begin
      mLock = 0; mKey = 0; mErr = 0;
    end else if (!sysRstN) begin
      mKey = 0; mErr = 0;
    end else begin
      mErr = deny;
      if (setOk) begin
        mLock = 1; mKey = 0;
      end else if (keyWrEn) mKey = longint'(keyWrData);
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle();
    keyWrEn = 0; lockWrEn = 0; lockWrBit = 0; keyWrData = '0;
    iReqValid = 0; dReqValid = 0; pgmValid = 0; pageValid = 0; massValid = 0;
  endtask

  task automatic doReads(input logic [DW-1:0] a, input logic [DW-1:0] b);
    idle(); iReqValid = 1; dReqValid = 1; iFlashData = a; dFlashData = b; step();
    idle(); iReqValid = 1; iFlashData = b; step();
    idle(); dReqValid = 1; dFlashData = a; step();
  endtask

  task automatic doWrites();
    idle(); pgmValid = 1; pgmAddr = 12'hA5C; pgmData = 32'h1357_9BDF; step();
    idle(); step();
    for (int p = 0; p < NP; p++) begin
      idle(); pageValid = 1; pageIdx = PW'(p); step();
    end
    idle(); massValid = 1; step();
    idle(); pgmValid = 1; pageValid = 1; pageIdx = 3'd2; massValid = 1; step();
    idle(); step();
  endtask

  initial begin
    porRstN = 0; sysRstN = 0; idle();
    wrProt = '0; iFlashData = '0; dFlashData = '0;
    pgmAddr = '0; pgmData = '0; pageIdx = '0;
    @(negedge clk);
    step(); step();
    porRstN = 1; sysRstN = 1;
    step();
    // R6 unlocked reads, R7/R8/R9 writes with protection patterns
    doReads(32'hDEAD_BEEF, 32'h0F0F_1234);
    wrProt = 8'b0000_0100; doWrites();
    wrProt = 8'b0000_0000; doWrites();
    // R3: set attempt with empty key, then with a wrong key
    idle(); lockWrEn = 1; lockWrBit = 1; step();
    idle(); keyWrEn = 1; keyWrData = KEY ^ 32'h1; step();
    idle(); lockWrEn = 1; lockWrBit = 1; step();
    idle(); step();
    // R1: load key, write zero to the lock, then set with a key write in the same cycle (R4)
    idle(); keyWrEn = 1; keyWrData = KEY; step();
    idle(); lockWrEn = 1; lockWrBit = 0; step();
    idle(); lockWrEn = 1; lockWrBit = 1; keyWrEn = 1; keyWrData = KEY; step();
    idle(); step(); step();
    // R5 locked reads, R7/R8/R9/R10 locked writes
    doReads(32'hCAFE_F00D, 32'h8000_0001);
    wrProt = 8'b1000_0001; doWrites();
    wrProt = 8'b0000_0000; doWrites();
    wrProt = 8'hFF; doWrites();
    // R1: attempts to clear by writing
    idle(); keyWrEn = 1; keyWrData = KEY; step();
    idle(); lockWrEn = 1; lockWrBit = 0; step();
    idle(); step();
    // R2: soft reset keeps the lock, clears key and pending error
    idle(); pgmValid = 1; step();
    sysRstN = 0; idle(); step(); step();
    sysRstN = 1; idle(); step();
    doReads(32'h1111_2222, 32'h3333_4444);
    // R2: power-on reset clears the lock; lock write during reset ignored
    porRstN = 0; idle(); keyWrEn = 1; keyWrData = KEY; step();
    idle(); lockWrEn = 1; lockWrBit = 1; step();
    porRstN = 1; idle(); step();
    doReads(32'h5555_6666, 32'h7777_8888);
    wrProt = 8'b0100_0000; doWrites();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule